// File: doc/BRIEF.md
# Hardware Monitor Register Access Port

This block is the register front end of a hardware monitor. A host sees only two byte-wide ports: writing the index port chooses one of the internal 8-bit registers, and reads or writes on the data port then reach that register. The index stays where it was put; data accesses never move it.

The block holds a run/configuration register, a 12-bit low-limit register for each fan, and a control byte for each fan. It also presents the live 12-bit fan counts, which arrive on an input bus from the measurement logic. Each 12-bit quantity occupies an even/odd index pair: the even index carries the upper bits, zero-extended to a byte, and the odd index carries the lower byte. A measured count keeps changing while the host reads it in two steps. To keep the two halves consistent, reading the upper half captures the lower byte in a per-fan holding register, and the following lower-half read returns that captured byte.

The block drives two control outputs: a monitoring-run flag and one enable line per fan.

Top module: `hwm_index_port`

## Requirements
- R1: Reset (synchronous, active high) leaves the index at 0x00, the configuration byte at 0x00, the read data at 0x00, the run flag low, every fan-limit register at 0xFFF and every fan enable high.
- R2: A write to port select 0 loads the index. A read of port select 0 returns the index. Any read places its byte on the read-data output at the clock edge where the read is sampled, and that byte holds until the next read.
- R3: Index 0x00 is a read/write configuration byte. The run flag goes high when bit 0 of that byte is 1 and bit 6 is 0, and it is low in every other case.
- R4: Reading index 0x20+2n returns fan n's live count bits 11..8 in data bits 3..0, with data bits 7..4 reading as zero.
- R5: Reading index 0x20+2n also captures fan n's count bits 7..0. The next read of index 0x21+2n returns the captured byte, even if the live count has changed in between.
- R6: A read of index 0x21+2n with no capture pending returns the live low byte. That read consumes any pending capture, so a second low read returns the live value again. Each fan has its own capture.
- R7: Every read of a high index reloads the capture, so a later low read returns the byte taken at the most recent high read.
- R8: The count indices are read-only. Writes to them change neither the values read back nor a pending capture.
- R9: Indices 0x28+2n (bits 11..8, held in data bits 3..0, with bits 7..4 reading zero) and 0x29+2n (bits 7..0) hold fan n's 12-bit low limit. Each fan's limit is separate from the others.
- R10: Index 0x60+16n is fan n's read/write control byte. Fan n's enable output is the inverse of bit 7 of that byte.
- R11: Any index that is not mapped reads as 0x00 and ignores writes.
- R12: Data-port accesses leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write byte |
| fan_cnt_i | input | NFAN*CNT_W | Live fan counts, fan 0 in the lowest bits |
| io_rdata_o | output | 8 | Registered read byte |
| mon_run_o | output | 1 | Monitoring run flag |
| fan_en_o | output | NFAN | Per-fan monitoring enable |

## Verification
The bench builds the block with NFAN=3 and CNT_W=12. Three fans are enough to show that each fan's capture register is separate from the others. These values also leave the gap at 0x26/0x27 between the last count pair and the first limit pair, and they place control bytes at 0x60, 0x70 and 0x80 with 0x90 unmapped, so the unmapped-index cases can be reached. Because the width is 12, the high bytes carry exactly four zero-extended bits.

// File: rtl/hwm_idx_pkg.sv
`timescale 1ns/1ps
package hwm_idx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] CFG_IDX   = 8'h00;
  localparam logic [7:0] CNT_BASE  = 8'h20;
  localparam logic [7:0] LIM_BASE  = 8'h28;
  localparam logic [7:0] CTRL_BASE = 8'h60;
  localparam int CTRL_STRIDE = 16;
  localparam logic PORT_INDEX = 1'b0;
  localparam logic PORT_DATA  = 1'b1;
  // bit positions inside the configuration byte
  localparam int CFG_RUN_BIT  = 0;
  localparam int CFG_HALT_BIT = 6;
  localparam int CTRL_OFF_BIT = 7;
endpackage

// File: rtl/hwm_cnt_snap.sv
`timescale 1ns/1ps
// One fan's count pair: a zero-extended high byte, plus a low byte that is
// captured when the high byte is read.
module hwm_cnt_snap #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic [7:0]       hi_o,
  output logic [7:0]       lo_o
);
  logic [7:0] hold_q;
  logic       held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      held_q <= 1'b0;
    end else if (rd_hi_i) begin
      hold_q <= cnt_i[7:0];
      held_q <= 1'b1;
    end else if (rd_lo_i) begin
      held_q <= 1'b0;
    end
  end

  assign hi_o = 8'(cnt_i[CNT_W-1:8]);
  assign lo_o = held_q ? hold_q : cnt_i[7:0];
endmodule

// File: rtl/hwm_lim_reg.sv
`timescale 1ns/1ps
// One fan's 12-bit (CNT_W) low-limit register, split across two indices.
module hwm_lim_reg #(
  parameter int               CNT_W   = 12,
  parameter logic [CNT_W-1:0] RST_VAL = '1,
  localparam int              HI_W    = CNT_W - 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  input  logic [HI_W-1:0] wdata_hi_i,
  input  logic [7:0]      wdata_lo_i,
  output logic [7:0]      hi_o,
  output logic [7:0]      lo_o
);
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= RST_VAL;
    end else begin
      if (wr_hi_i) lim_q[CNT_W-1:8] <= wdata_hi_i;
      if (wr_lo_i) lim_q[7:0]       <= wdata_lo_i;
    end
  end

  assign hi_o = 8'(lim_q[CNT_W-1:8]);
  assign lo_o = lim_q[7:0];
endmodule

// File: rtl/hwm_fan_ctrl.sv
`timescale 1ns/1ps
// One fan's control byte, plus a registered enable output.
module hwm_fan_ctrl #(
  parameter int OFF_BIT = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output logic       en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      en_o   <= 1'b1;
    end else if (wr_i) begin
      ctrl_o <= wdata_i;
      en_o   <= ~wdata_i[OFF_BIT];
    end
  end
endmodule

// File: rtl/hwm_index_port.sv
`timescale 1ns/1ps
// Index/data register port. NFAN must be at most 4 so that the count pairs
// fit below the limit base. CNT_W must lie between 9 and 16.
module hwm_index_port
  import hwm_idx_pkg::*;
#(
  parameter int NFAN  = 3,
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_sel,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  input  logic [NFAN*CNT_W-1:0] fan_cnt_i,
  output logic [7:0]            io_rdata_o,
  output logic                  mon_run_o,
  output logic [NFAN-1:0]       fan_en_o
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [7:0] idx_q;
  logic [7:0] cfg_q;
  logic [7:0] rd_mux;
  logic       idx_wr;
  logic       data_wr;
  logic       data_rd;
  logic [7:0] fan_rd_b [NFAN];

  assign idx_wr  = io_wr && (io_sel == PORT_INDEX);
  assign data_wr = io_wr && (io_sel == PORT_DATA);
  assign data_rd = io_rd && (io_sel == PORT_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      cfg_q     <= '0;
      mon_run_o <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= io_wdata;
      if (data_wr && idx_q == CFG_IDX) begin
        cfg_q     <= io_wdata;
        mon_run_o <= io_wdata[CFG_RUN_BIT] & ~io_wdata[CFG_HALT_BIT];
      end
    end
  end

  genvar n;
  generate
    for (n = 0; n < NFAN; n++) begin : g_fan
      localparam logic [7:0] I_CNT = 8'(int'(CNT_BASE) + 2*n);
      localparam logic [7:0] I_LIM = 8'(int'(LIM_BASE) + 2*n);
      localparam logic [7:0] I_CTL = 8'(int'(CTRL_BASE) + CTRL_STRIDE*n);

      logic       hit_cnt_hi, hit_cnt_lo, hit_lim_hi, hit_lim_lo, hit_ctl;
      logic [7:0] cnt_hi, cnt_lo, lim_hi, lim_lo, ctl_b;

      assign hit_cnt_hi = (idx_q == I_CNT);
      assign hit_cnt_lo = (idx_q == I_CNT + 8'd1);
      assign hit_lim_hi = (idx_q == I_LIM);
      assign hit_lim_lo = (idx_q == I_LIM + 8'd1);
      assign hit_ctl    = (idx_q == I_CTL);

      hwm_cnt_snap #(.CNT_W(CNT_W)) snap_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_i   (fan_cnt_i[n*CNT_W +: CNT_W]),
        .rd_hi_i (data_rd && hit_cnt_hi),
        .rd_lo_i (data_rd && hit_cnt_lo),
        .hi_o    (cnt_hi),
        .lo_o    (cnt_lo)
      );

      hwm_lim_reg #(.CNT_W(CNT_W), .RST_VAL('1)) lim_i (
        .clk        (clk),
        .rst        (rst),
        .wr_hi_i    (data_wr && hit_lim_hi),
        .wr_lo_i    (data_wr && hit_lim_lo),
        .wdata_hi_i (io_wdata[HI_W-1:0]),
        .wdata_lo_i (io_wdata),
        .hi_o       (lim_hi),
        .lo_o       (lim_lo)
      );

      hwm_fan_ctrl #(.OFF_BIT(CTRL_OFF_BIT)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (data_wr && hit_ctl),
        .wdata_i (io_wdata),
        .ctrl_o  (ctl_b),
        .en_o    (fan_en_o[n])
      );

      assign fan_rd_b[n] = hit_cnt_hi ? cnt_hi :
                           hit_cnt_lo ? cnt_lo :
                           hit_lim_hi ? lim_hi :
                           hit_lim_lo ? lim_lo :
                           hit_ctl    ? ctl_b  : 8'h00;
    end
  endgenerate

  always_comb begin
    rd_mux = (idx_q == CFG_IDX) ? cfg_q : 8'h00;
    for (int k = 0; k < NFAN; k++) rd_mux = rd_mux | fan_rd_b[k];
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata_o <= '0;
    else if (io_rd) io_rdata_o <= (io_sel == PORT_DATA) ? rd_mux : idx_q;
  end
endmodule

// File: rtl/hwm_index_port_chk.sv
`timescale 1ns/1ps
module hwm_index_port_chk
  import hwm_idx_pkg::*;
#(
  parameter int NFAN  = 3,
  parameter int CNT_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            io_sel,
  input logic            io_wr,
  input logic            io_rd,
  input logic [7:0]      io_wdata,
  input logic [7:0]      io_rdata_o,
  input logic            mon_run_o,
  input logic [NFAN-1:0] fan_en_o,
  input logic [7:0]      idx_q
);
  localparam int CNT_END = int'(CNT_BASE) + 2*NFAN;

  logic cnt_hi_sel;
  assign cnt_hi_sel = (int'(idx_q) >= int'(CNT_BASE)) && (int'(idx_q) < CNT_END) && !idx_q[0];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (io_rdata_o == 8'h00 && !mon_run_o && fan_en_o == '1));

  p_index_load_r2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_sel == PORT_INDEX) |=> idx_q == $past(io_wdata));

  p_index_read_r2: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_sel == PORT_INDEX && !io_wr) |=> io_rdata_o == $past(idx_q));

  p_run_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_sel == PORT_DATA && idx_q == CFG_IDX)
      |=> mon_run_o == ($past(io_wdata[CFG_RUN_BIT]) && !$past(io_wdata[CFG_HALT_BIT])));

  p_cnt_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_sel == PORT_DATA && cnt_hi_sel) |=> (io_rdata_o >> (CNT_W - 8)) == 8'h00);

  p_fan0_en_r10: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_sel == PORT_DATA && idx_q == CTRL_BASE)
      |=> fan_en_o[0] == !$past(io_wdata[CTRL_OFF_BIT]));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_sel == PORT_DATA && idx_q == 8'hFF) |=> io_rdata_o == 8'h00);

  p_index_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_sel == PORT_INDEX) |=> $stable(idx_q));
endmodule

bind hwm_index_port hwm_index_port_chk #(.NFAN(NFAN), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_sel     (io_sel),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_wdata   (io_wdata),
  .io_rdata_o (io_rdata_o),
  .mon_run_o  (mon_run_o),
  .fan_en_o   (fan_en_o),
  .idx_q      (idx_q)
);

// File: tb/hwm_index_port_tb_top.sv
`timescale 1ns/1ps
module hwm_index_port_tb_top;
  localparam int NFAN  = 3;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst = 1'b1;
  logic                  io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]            io_wdata = '0;
  logic [NFAN*CNT_W-1:0] fan_cnt_i = '0;
  logic [7:0]            io_rdata_o;
  logic                  mon_run_o;
  logic [NFAN-1:0]       fan_en_o;

  hwm_index_port #(.NFAN(NFAN), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .fan_cnt_i(fan_cnt_i), .io_rdata_o(io_rdata_o),
    .mon_run_o(mon_run_o), .fan_en_o(fan_en_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one edge after the strobe
  always @(posedge clk) rd_d <= io_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected read result", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(io_rdata_o), int'(e));
      end
    end
  end

  task automatic put(input logic sel, input logic [7:0] v);
    io_sel = sel; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic get(input logic sel, input logic [7:0] exp, input string tag);
    io_sel = sel; io_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic set_fan(input int n, input logic [CNT_W-1:0] v);
    fan_cnt_i[n*CNT_W +: CNT_W] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(io_rdata_o), 0);
    check("R1 run", int'(mon_run_o), 0);
    check("R1 fan_en", int'(fan_en_o), 7);
    rst = 1'b0;
    @(negedge clk);
    get(1'b0, 8'h00, "R1 index reset");
    get(1'b1, 8'h00, "R1 cfg reset");

    // R2 index port
    put(1'b0, 8'h20);
    get(1'b0, 8'h20, "R2 index readback");

    // R4 / R5 coherent pair read
    set_fan(0, 12'hABC); set_fan(1, 12'h123); set_fan(2, 12'hFED);
    get(1'b1, 8'h0A, "R4 fan0 high");
    set_fan(0, 12'h5C7);
    put(1'b0, 8'h21);
    get(1'b1, 8'hBC, "R5 fan0 low captured");
    get(1'b1, 8'hC7, "R6 capture consumed, live low");

    // R7 reload on each high read
    put(1'b0, 8'h20);
    get(1'b1, 8'h05, "R7 first high");
    set_fan(0, 12'h6D1);
    get(1'b1, 8'h06, "R7 second high");
    set_fan(0, 12'h7E2);
    put(1'b0, 8'h21);
    get(1'b1, 8'hD1, "R7 low from latest capture");

    // R6 separate captures per fan
    put(1'b0, 8'h22);
    get(1'b1, 8'h01, "R4 fan1 high");
    set_fan(1, 12'h456);
    put(1'b0, 8'h25);
    get(1'b1, 8'hED, "R6 fan2 low live");
    put(1'b0, 8'h23);
    get(1'b1, 8'h23, "R6 fan1 low captured");
    put(1'b0, 8'h24);
    get(1'b1, 8'h0F, "R4 fan2 high");

    // R8 counts are read-only
    put(1'b0, 8'h20);
    put(1'b1, 8'hFF);
    get(1'b1, 8'h07, "R8 fan0 high after write");
    put(1'b0, 8'h21);
    put(1'b1, 8'h00);
    get(1'b1, 8'hE2, "R8 capture survives write");

    // R9 limits
    put(1'b0, 8'h2A);
    get(1'b1, 8'h0F, "R9 fan1 limit high reset");
    put(1'b1, 8'h93);
    get(1'b1, 8'h03, "R9 fan1 limit high masked");
    put(1'b0, 8'h2B);
    get(1'b1, 8'hFF, "R9 fan1 limit low reset");
    put(1'b1, 8'h44);
    get(1'b1, 8'h44, "R9 fan1 limit low");
    put(1'b0, 8'h28);
    get(1'b1, 8'h0F, "R9 fan0 limit untouched");

    // R3 run flag
    put(1'b0, 8'h00);
    put(1'b1, 8'h01);
    check("R3 run on", int'(mon_run_o), 1);
    get(1'b1, 8'h01, "R3 cfg readback");
    put(1'b1, 8'h41);
    check("R3 halt bit blocks run", int'(mon_run_o), 0);
    get(1'b1, 8'h41, "R3 cfg readback 2");
    put(1'b1, 8'h40);
    check("R3 run off", int'(mon_run_o), 0);
    put(1'b1, 8'h81);
    check("R3 run on other bits", int'(mon_run_o), 1);

    // R10 fan control
    put(1'b0, 8'h70);
    put(1'b1, 8'h80);
    check("R10 fan1 disabled", int'(fan_en_o), 5);
    get(1'b1, 8'h80, "R10 ctrl1 readback");
    put(1'b0, 8'h60);
    put(1'b1, 8'h7F);
    check("R10 fan0 still enabled", int'(fan_en_o), 5);
    get(1'b1, 8'h7F, "R10 ctrl0 readback");
    put(1'b0, 8'h80);
    put(1'b1, 8'h80);
    check("R10 fan2 disabled", int'(fan_en_o), 1);
    put(1'b0, 8'h70);
    put(1'b1, 8'h00);
    check("R10 fan1 re-enabled", int'(fan_en_o), 3);

    // R11 unmapped
    put(1'b0, 8'h26);
    put(1'b1, 8'h55);
    get(1'b1, 8'h00, "R11 gap index");
    put(1'b0, 8'h90);
    put(1'b1, 8'h80);
    get(1'b1, 8'h00, "R11 beyond last ctrl");
    check("R11 fan_en unchanged", int'(fan_en_o), 3);
    put(1'b0, 8'h61);
    put(1'b1, 8'hFF);
    get(1'b1, 8'h00, "R11 between ctrl");
    check("R11 run unchanged", int'(mon_run_o), 1);

    // R12 index unchanged by data access
    get(1'b0, 8'h61, "R12 index after data access");
    put(1'b0, 8'h00);
    get(1'b1, 8'h81, "R11 cfg untouched");

    repeat (3) @(negedge clk);
    check("R2 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule